// File: doc/BRIEF.md
# Serial Shift and Store Register

This block turns a serial bit stream into a parallel word. A chain of flip-flops takes one bit from the serial input on every rising edge of the clock. A storage stage sits behind the chain and copies it while a strobe is high, so the parallel word changes only when the system asks for it. An output enable decides whether the parallel outputs drive the stored word. The three-state buffer is modelled as a data-plus-enable pair, so the chip-level pad or mux does the actual driving.

Two serial taps at the far end of the chain let several blocks be chained into one longer register. The first tap changes on the rising edge. The second tap is re-timed to the falling edge, which gives the next block half a clock period of margin against clock skew. A synchronous active-low reset clears all state so that the contents are known after reset.

Top module: `shift_store_reg`

## Requirements
- R1: On every rising clock edge with reset inactive, `ser_in` enters stage 0 and each stage k (k >= 1) takes the previous value of stage k-1. Stage 0 is bit 0 of the parallel word, nearest the serial input.
- R2: When `strobe` is high at a rising edge, `par_q` shows, right after that edge, the chain contents as updated by that edge. This models a transparent storage latch at clock-cycle granularity.
- R3: When `strobe` is low at a rising edge, `par_q` keeps its previous value.
- R4: `par_oe` is all ones while `out_en` is 1 and all zeros while `out_en` is 0. `par_q` always carries the stored word, which is the value that is driven when `par_oe` is set.
- R5: `out_en` never changes the chain contents or the stored word.
- R6: `ser_out_rise` equals the last stage (stage STAGES-1) and so changes only on rising edges.
- R7: `ser_out_fall` captures the last stage on each falling edge and keeps that value through the following rising edge.
- R8: Both serial taps keep operating whatever the values of `out_en` and `strobe`.
- R9: When `rst_n` is 0 at a clock edge, the chain, the stored word and both serial taps clear to 0 (the falling-edge tap clears at a falling edge).
- R10: When `ser_out_fall` of one block feeds `ser_in` of a second block, the pair acts as one chain of 2*STAGES stages. After 16 shifts, the first block holds the most recently shifted 8 bits and the second block holds the 8 bits before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the chain moves on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High: the storage stage follows the chain |
| out_en | input | 1 | High: the parallel outputs are driven |
| par_q | output | STAGES | Stored word; bit k comes from stage k |
| par_oe | output | STAGES | Per-bit drive enable for the three-state pads |
| ser_out_rise | output | 1 | Last stage, changes on the rising edge |
| ser_out_fall | output | 1 | Last stage re-timed to the falling edge |

## Verification
Every 8-bit word is shifted in MSB first, with the strobe raised only on the final shift. Reading each word back exactly proves the bit order and the shift. Reading the previous word just before that final shift proves the hold. Toggling `out_en` with each word shows that the enable only gates `par_oe`. A run with the strobe held high over eight shifts separates true following from a single capture at the end. Sixteen-bit words with single set bits at either end, and mixed words, are pushed through two cascaded blocks; these show that the falling-edge tap neither drops nor duplicates a bit between the two blocks.

// File: rtl/shift_store_pkg.sv
// Package: shared constants and types for the serial shift and store register.
// Assumes: nothing; it holds declarations only.
package shift_store_pkg;
    localparam int unsigned DEFAULT_STAGES = 8;

    // The two cascade taps taken from the last stage.
    typedef struct packed {
        logic rise;
        logic fall;
    } ser_tap_t;
endpackage

// File: rtl/ssr_shift_chain.sv
// Module: serial-in chain of STAGES flip-flops.
// Does: shifts ser_in into stage 0 on every rising edge and exposes both the
//       current contents and the next-state vector for the storage stage.
// Assumes: STAGES >= 2; rst_n is synchronous and active low.
module ssr_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q,
    output logic [STAGES-1:0] stage_d
);
    // Next-state wiring: stage 0 from the input, the rest from their neighbour.
    assign stage_d[0] = ser_in;
    for (genvar g = 1; g < STAGES; g++) begin : g_link
        assign stage_d[g] = stage_q[g-1];
    end

    // Chain register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/ssr_store_stage.sv
// Module: storage stage behind the chain.
// Does: while strobe is high, captures the chain's next state so that right
//       after the edge it equals the chain; while strobe is low it holds.
// Assumes: the chain only changes on rising edges, so edge-time capture shows
//          the same values a transparent latch would at cycle granularity.
module ssr_store_stage #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [STAGES-1:0] chain_next,
    output logic [STAGES-1:0] store_q
);
    // Storage register: follow while strobed, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      store_q <= '0;
        else if (strobe) store_q <= chain_next;
    end
endmodule

// File: rtl/ssr_fall_retime.sv
// Module: falling-edge re-timing flop for the second cascade tap.
// Does: samples the last stage on the falling edge and holds it across the
//       next rising edge.
// Assumes: rst_n stays stable around the falling edge (it changes after rising edges).
module ssr_fall_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic last_stage,
    output logic fall_q
);
    // Half-cycle re-timing register with synchronous clear.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= last_stage;
    end
endmodule

// File: rtl/shift_store_reg.sv
// Module: serial shift and store register, top level.
// Does: chain + storage stage + output enable + two cascade taps.
//       The three-state parallel output is given as data (par_q) plus a
//       per-bit enable (par_oe) for the pad ring.
// Assumes: STAGES >= 2; rst_n is synchronous, active low, and changes away
//          from both clock edges.
module shift_store_reg
    import shift_store_pkg::*;
#(
    parameter int unsigned STAGES = DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              strobe,
    input  logic              out_en,
    output logic [STAGES-1:0] par_q,
    output logic [STAGES-1:0] par_oe,
    output logic              ser_out_rise,
    output logic              ser_out_fall
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;
    logic [STAGES-1:0] store_q;
    ser_tap_t          tap;

    ssr_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (stage_q),
        .stage_d (stage_d)
    );

    ssr_store_stage #(.STAGES(STAGES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .chain_next (stage_d),
        .store_q    (store_q)
    );

    // Rising tap: the last stage itself.
    assign tap.rise = stage_q[LAST];

    ssr_fall_retime u_fall (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_stage (stage_q[LAST]),
        .fall_q     (tap.fall)
    );

    // Output drive: stored word as data, enable replicated to each bit.
    assign par_q        = store_q;
    assign par_oe       = {STAGES{out_en}};
    assign ser_out_rise = tap.rise;
    assign ser_out_fall = tap.fall;

    // R1: the chain moved by exactly one position.
    assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q == {$past(stage_q[LAST-1:0]), $past(ser_in)});

    // R2: a strobed edge leaves the stored word equal to the chain.
    assert_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(strobe)) |-> par_q == stage_q);

    // R3 / R5: with no strobe the stored word is stable, whatever out_en does.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(strobe)) |-> par_q == $past(par_q));

    // R7: at a rising edge the falling tap still shows the rising tap's value.
    assert_fall_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ser_out_fall == ser_out_rise);

    // R9: reset clears the stored word and the rising tap.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (par_q == '0 && !ser_out_rise));
endmodule

// File: tb/shift_store_reg_tb_top.sv
// Bench: one block alone (dut_i) and a second block (dut_b) cascaded behind it
// through the falling-edge tap. Expected values are computed from bit positions.
module shift_store_reg_tb_top;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sin = 1'b0;
    logic strobe = 1'b0;
    logic out_en = 1'b0;
    logic [N-1:0] par_a, oe_a, par_b, oe_b;
    logic rise_a, fall_a, rise_b, fall_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shift_store_reg #(.STAGES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(sin), .strobe(strobe), .out_en(out_en),
        .par_q(par_a), .par_oe(oe_a), .ser_out_rise(rise_a), .ser_out_fall(fall_a)
    );

    shift_store_reg #(.STAGES(N)) dut_b (
        .clk(clk), .rst_n(rst_n), .ser_in(fall_a), .strobe(strobe), .out_en(out_en),
        .par_q(par_b), .par_oe(oe_b), .ser_out_rise(rise_b), .ser_out_fall(fall_b)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // One rising edge; returns 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic to_fall();
        @(negedge clk);
        #1;
    endtask

    initial begin
        logic [N-1:0] prev;
        logic [N-1:0] cur;
        logic [15:0] words [4];

        // R9: reset state.
        rst_n = 1'b0; out_en = 1'b1;
        repeat (3) tick();
        check("R9 par_q", 16'(par_a), 16'h0);
        check("R9 rise", 16'(rise_a), 16'h0);
        check("R4 oe on", 16'(oe_a), 16'h00FF);
        to_fall();
        check("R9 fall", 16'(fall_a), 16'h0);
        tick();
        rst_n = 1'b1;

        // Sweep all words MSB first, strobe only on the last shift, out_en = v[0].
        prev = '0;
        for (int v = 0; v < 256; v++) begin
            logic [N-1:0] w;
            w = N'(v);
            for (int e = 0; e < N; e++) begin
                sin = w[N-1-e];
                strobe = (e == N-1);
                out_en = w[0];
                if (e == N-1) check("R3 hold before strobe", 16'(par_a), 16'(prev));
                tick();
            end
            check("R1 R2 R5 word", 16'(par_a), 16'(w));
            check("R6 rise tap", 16'(rise_a), 16'(w[N-1]));
            check("R7 fall holds over rise", 16'(fall_a), 16'(prev[0]));
            check("R4 oe", 16'(oe_a), {8'h0, {N{w[0]}}});
            to_fall();
            check("R7 R8 fall tap", 16'(fall_a), 16'(w[N-1]));
            prev = w;
        end

        // R2: strobe held high, stored word follows every shift.
        cur = prev;
        strobe = 1'b1;
        out_en = 1'b1;
        for (int e = 0; e < N; e++) begin
            logic b;
            b = 8'h36 >> (N-1-e);
            sin = b;
            tick();
            cur = {cur[N-2:0], b};
            check("R2 follow", 16'(par_a), 16'(cur));
        end
        strobe = 1'b0; sin = 1'b1;
        tick();
        check("R3 hold after follow", 16'(par_a), 16'(cur));

        // R10: 16-bit words through the cascaded pair, out_en low while shifting.
        words[0] = 16'hC3A9; words[1] = 16'h0001; words[2] = 16'h8000; words[3] = 16'h5A5A;
        for (int k = 0; k < 4; k++) begin
            out_en = 1'b0;
            for (int e = 0; e < 16; e++) begin
                sin = words[k][15-e];
                strobe = (e == 15);
                tick();
            end
            strobe = 1'b0;
            check("R10 near block", 16'(par_a), 16'(words[k][7:0]));
            check("R10 far block", 16'(par_b), 16'(words[k][15:8]));
            check("R4 oe off", 16'({oe_b, oe_a}), 16'h0000);
            out_en = 1'b1;
            #1;
            check("R4 oe on pair", 16'({oe_b, oe_a}), 16'hFFFF);
            check("R5 word kept", 16'({par_b, par_a}), words[k]);
        end

        // R9: reset in mid-run clears everything.
        rst_n = 1'b0;
        tick();
        check("R9 mid par", 16'({par_b, par_a}), 16'h0);
        check("R9 mid rise", 16'({rise_b, rise_a}), 16'h0);
        to_fall();
        check("R9 mid fall", 16'({fall_b, fall_a}), 16'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule